// File: doc/BRIEF.md
# Content-Addressable Memory Host Command and Register Interface

This block sits between a host bus and the lookup core of a content-addressable memory. Each clock in which the active-low enable is asserted is one bus cycle. Two strobes sort that cycle into one of four kinds: command write, command read, data write or data read. Command writes carry a 16-bit instruction on the upper half of the 32-bit bus and a 16-bit value on the lower half.

An override instruction either loads one of the host-visible registers at once, or arms a read that the very next command read answers. Two select instructions choose which resource later data cycles reach. Data cycles do not touch any storage here. Each one issues a single-cycle request that names the resource, the direction and, where relevant, the array address, and the core beyond this block carries it out.

A device-select register compared against a page register decides whether the device answers at all. An all-ones select code makes the device accept writes only. Read data is driven in the same clock as the read cycle. Register state changes at the clock edge that ends the cycle.

Top module: `cam_host_if`

## Requirements
- R1: With `bus_en_n` high nothing happens: `dq_oe` is 0 and `req_vld` is 0. With it low, {`bus_cd`,`bus_wr_n`} = 00 is a command write, 01 a command read, 10 a data write and 11 a data read.
- R2: A command read with no armed read drives the whole 32-bit `status_in` on `dq_out` with `dq_oe` = 1.
- R3: A command write whose instruction field `dq_in[31:16]` has bits [15:12] = 1 (override) and bit 4 = 1 loads `dq_in[15:0]` into the register named by bits [3:0]: 0 address, 1 control, 2 page, 3 segment control, 4 device select. Codes 5 to 15 load nothing.
- R4: An override with bit 4 = 0 arms a read. If the next clock is a command read, `dq_out` = {`status_in[31:16]`, register}. Codes 0 to 4 are as in R3, code 5 is `nfa_in`, and any code above 7 returns plain status.
- R5: An armed read of the page register (code 2) returns zeros on `dq_out[31:16]`.
- R6: After reset the comparand (resource 0) is both source and destination. Instruction bits [15:12] = 2 select the source and = 3 select the destination, with the resource in bits [2:0]: 0 comparand, 1 mask 1, 2 mask 2, 3 array at the address register, 4 array at the next-free address, 5 array at the highest-priority match. Selecting 0 restores the comparand.
- R7: Every accepted data cycle raises `req_vld` for that clock. `req_wr` is 1 for writes, and `req_res` is the destination on writes or the source on reads. `req_addr` is the address register for resource 3, `nfa_in` for resource 4 and 0 otherwise. A data read drives `rd_data_in` on `dq_out`.
- R8: When device select differs from page, no read is answered (`dq_oe` = 0, no request) and no write is accepted. The exception is a device select of FFFFh, which accepts writes only. A load of device select (override code 4) is always accepted.
- R9: An armed read with code 6 returns {`DEV_ID`, last accepted source-select instruction}. Code 7 returns {`status_in[31:16]`, last accepted destination-select instruction}. Both instruction copies reset to 0.
- R10: An armed read is dropped by any clock that is not a command read, including a clock with `bus_en_n` high. A later command read then returns plain status.
- R11: A source select naming resource 4, 6 or 7, or a destination select naming 6 or 7, changes neither the selection nor its stored instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en_n | input | 1 | Cycle enable, active low |
| bus_cd | input | 1 | 0 command cycle, 1 data cycle |
| bus_wr_n | input | 1 | 0 write, 1 read |
| dq_in | input | 32 | Bus data from host |
| dq_out | output | 32 | Bus data to host, 0 when not driven |
| dq_oe | output | 1 | Bus drive enable |
| nfa_in | input | 16 | Next-free address from the core |
| status_in | input | 32 | Status word from the core |
| rd_data_in | input | 32 | Data-read result from the core |
| req_vld | output | 1 | One-cycle data request strobe |
| req_wr | output | 1 | Request direction, 1 write |
| req_res | output | 3 | Requested resource code |
| req_addr | output | 16 | Array address for the request |
| req_wdata | output | 32 | Write data of the request |

## Verification
The checker assumes that the host holds the strobes and data stable around each rising edge and treats each enabled clock as exactly one cycle. It also assumes that reset is held for at least one edge before any cycle starts. The bench drives all inputs on the falling edge and leaves `nfa_in`, `status_in` and `rd_data_in` at fixed distinct patterns, so that every field of `dq_out` and `req_addr` can be traced to its origin. Deselection is only entered through device-select loads, which the block always accepts, so the stimulus can always leave that state again.

// File: rtl/cam_host_pkg.sv
package cam_host_pkg;
   typedef enum logic [1:0] {
      CYC_CMD_WR = 2'd0,
      CYC_CMD_RD = 2'd1,
      CYC_DAT_WR = 2'd2,
      CYC_DAT_RD = 2'd3
   } cyc_e;

   typedef enum logic [2:0] {
      RES_CMP     = 3'd0,
      RES_MSK1    = 3'd1,
      RES_MSK2    = 3'd2,
      RES_ARR_ADR = 3'd3,
      RES_ARR_NFA = 3'd4,
      RES_ARR_HPM = 3'd5
   } res_e;

   localparam logic [3:0] OP_OVR = 4'd1;
   localparam logic [3:0] OP_SRC = 4'd2;
   localparam logic [3:0] OP_DST = 4'd3;

   localparam int         NUM_LD  = 5;
   localparam logic [3:0] RG_ADR  = 4'd0;
   localparam logic [3:0] RG_CTL  = 4'd1;
   localparam logic [3:0] RG_PAGE = 4'd2;
   localparam logic [3:0] RG_SEG  = 4'd3;
   localparam logic [3:0] RG_DSEL = 4'd4;
   localparam logic [3:0] RG_NFA  = 4'd5;
   localparam logic [3:0] RG_SRC  = 4'd6;
   localparam logic [3:0] RG_DST  = 4'd7;

   localparam int FLAG_BIT = 4;
endpackage

// File: rtl/cam_cycle_decode.sv
module cam_cycle_decode
   import cam_host_pkg::*;
#(
   parameter int REG_W    = 16,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic             bus_en_n,
   input  logic             bus_cd,
   input  logic             bus_wr_n,
   input  logic [REG_W-1:0] dsel_q,
   input  logic [REG_W-1:0] page_q,
   output logic             cyc_act,
   output cyc_e             cyc_type,
   output logic             rd_ok,
   output logic             wr_ok
);
   logic sel_eq;

   assign cyc_act  = !bus_en_n;
   assign cyc_type = cyc_e'({bus_cd, bus_wr_n});
   assign sel_eq   = (dsel_q == page_q);
   assign rd_ok    = sel_eq;

   generate
      if (BCAST_EN) begin : g_bcast
         assign wr_ok = sel_eq || (&dsel_q);
      end else begin : g_strict
         assign wr_ok = sel_eq;
      end
   endgenerate
endmodule

// File: rtl/cam_reg_file.sv
module cam_reg_file
   import cam_host_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic             wr_ok,
   input  logic [REG_W-1:0] instr,
   input  logic [REG_W-1:0] wval,
   output logic [REG_W-1:0] adr_q,
   output logic [REG_W-1:0] ctl_q,
   output logic [REG_W-1:0] page_q,
   output logic [REG_W-1:0] seg_q,
   output logic [REG_W-1:0] dsel_q,
   output logic [REG_W-1:0] src_ins_q,
   output logic [REG_W-1:0] dst_ins_q,
   output res_e             src_q,
   output res_e             dst_q,
   output logic             pend_q,
   output logic [3:0]       pend_sel_q
);
   localparam int OP_LSB = REG_W - 4;

   logic [3:0]       op;
   logic             flag;
   logic [3:0]       rsel;
   logic [2:0]       rcode;
   logic             acc_wr;
   logic             src_ok;
   logic             dst_ok;
   logic [NUM_LD-1:0] ld_en;
   logic [REG_W-1:0] regs_q [NUM_LD];

   assign op     = instr[REG_W-1:OP_LSB];
   assign flag   = instr[FLAG_BIT];
   assign rsel   = instr[3:0];
   assign rcode  = instr[2:0];
   assign acc_wr = cmd_wr && wr_ok;
   assign src_ok = (rcode <= 3'd5) && (rcode != 3'd4);
   assign dst_ok = (rcode <= 3'd5);

   generate
      for (genvar g = 0; g < NUM_LD; g++) begin : g_ld
         if (g == int'(RG_DSEL)) begin : g_always
            assign ld_en[g] = cmd_wr && (op == OP_OVR) && flag && (rsel == 4'(g));
         end else begin : g_gated
            assign ld_en[g] = acc_wr && (op == OP_OVR) && flag && (rsel == 4'(g));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LD; i++) regs_q[i] <= '0;
         pend_q     <= 1'b0;
         pend_sel_q <= '0;
         src_q      <= RES_CMP;
         dst_q      <= RES_CMP;
         src_ins_q  <= '0;
         dst_ins_q  <= '0;
      end else begin
         for (int i = 0; i < NUM_LD; i++) begin
            if (ld_en[i]) regs_q[i] <= wval;
         end
         pend_q <= acc_wr && (op == OP_OVR) && !flag;
         if (acc_wr && (op == OP_OVR) && !flag) pend_sel_q <= rsel;
         if (acc_wr && (op == OP_SRC) && src_ok) begin
            src_q     <= res_e'(rcode);
            src_ins_q <= instr;
         end
         if (acc_wr && (op == OP_DST) && dst_ok) begin
            dst_q     <= res_e'(rcode);
            dst_ins_q <= instr;
         end
      end
   end

   assign adr_q  = regs_q[RG_ADR];
   assign ctl_q  = regs_q[RG_CTL];
   assign page_q = regs_q[RG_PAGE];
   assign seg_q  = regs_q[RG_SEG];
   assign dsel_q = regs_q[RG_DSEL];
endmodule

// File: rtl/cam_read_mux.sv
module cam_read_mux
   import cam_host_pkg::*;
#(
   parameter int             REG_W  = 16,
   parameter logic [REG_W-1:0] DEV_ID = '0
) (
   input  cyc_e               cyc_type,
   input  logic               pend_q,
   input  logic [3:0]         pend_sel_q,
   input  logic [REG_W-1:0]   adr_q,
   input  logic [REG_W-1:0]   ctl_q,
   input  logic [REG_W-1:0]   page_q,
   input  logic [REG_W-1:0]   seg_q,
   input  logic [REG_W-1:0]   dsel_q,
   input  logic [REG_W-1:0]   src_ins_q,
   input  logic [REG_W-1:0]   dst_ins_q,
   input  logic [REG_W-1:0]   nfa_in,
   input  logic [2*REG_W-1:0] status_in,
   input  logic [2*REG_W-1:0] rd_data_in,
   output logic [2*REG_W-1:0] rd_word
);
   logic [REG_W-1:0] st_hi;
   assign st_hi = status_in[2*REG_W-1:REG_W];

   always_comb begin
      rd_word = '0;
      if (cyc_type == CYC_DAT_RD) begin
         rd_word = rd_data_in;
      end else if (cyc_type == CYC_CMD_RD) begin
         rd_word = status_in;
         if (pend_q) begin
            case (pend_sel_q)
               RG_ADR:  rd_word = {st_hi, adr_q};
               RG_CTL:  rd_word = {st_hi, ctl_q};
               RG_PAGE: rd_word = {{REG_W{1'b0}}, page_q};
               RG_SEG:  rd_word = {st_hi, seg_q};
               RG_DSEL: rd_word = {st_hi, dsel_q};
               RG_NFA:  rd_word = {st_hi, nfa_in};
               RG_SRC:  rd_word = {DEV_ID, src_ins_q};
               RG_DST:  rd_word = {st_hi, dst_ins_q};
               default: rd_word = status_in;
            endcase
         end
      end
   end
endmodule

// File: rtl/cam_host_if.sv
module cam_host_if
   import cam_host_pkg::*;
#(
   parameter int               REG_W    = 16,
   parameter int               DATA_W   = 32,
   parameter logic [REG_W-1:0] DEV_ID   = 16'h0C3A,
   parameter bit               BCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en_n,
   input  logic              bus_cd,
   input  logic              bus_wr_n,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [REG_W-1:0]  nfa_in,
   input  logic [DATA_W-1:0] status_in,
   input  logic [DATA_W-1:0] rd_data_in,
   output logic              req_vld,
   output logic              req_wr,
   output logic [2:0]        req_res,
   output logic [REG_W-1:0]  req_addr,
   output logic [DATA_W-1:0] req_wdata
);
   generate
      if (DATA_W != 2 * REG_W) begin : g_bad_width
         $error("cam_host_if: DATA_W must be twice REG_W");
      end
      if (REG_W < 8) begin : g_bad_reg
         $error("cam_host_if: REG_W must be at least 8");
      end
   endgenerate

   cyc_e             cyc_type;
   logic             cyc_act;
   logic             rd_ok;
   logic             wr_ok;
   logic [REG_W-1:0] adr_q, ctl_q, page_q, seg_q, dsel_q, src_ins_q, dst_ins_q;
   res_e             src_q, dst_q;
   logic             pend_q;
   logic [3:0]       pend_sel_q;
   logic [DATA_W-1:0] rd_word;
   logic             is_rd;
   logic             is_dat;
   res_e             act_res;

   cam_cycle_decode #(.REG_W(REG_W), .BCAST_EN(BCAST_EN)) u_dec (
      .bus_en_n (bus_en_n),
      .bus_cd   (bus_cd),
      .bus_wr_n (bus_wr_n),
      .dsel_q   (dsel_q),
      .page_q   (page_q),
      .cyc_act  (cyc_act),
      .cyc_type (cyc_type),
      .rd_ok    (rd_ok),
      .wr_ok    (wr_ok)
   );

   cam_reg_file #(.REG_W(REG_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cyc_act && (cyc_type == CYC_CMD_WR)),
      .wr_ok      (wr_ok),
      .instr      (dq_in[DATA_W-1:REG_W]),
      .wval       (dq_in[REG_W-1:0]),
      .adr_q      (adr_q),
      .ctl_q      (ctl_q),
      .page_q     (page_q),
      .seg_q      (seg_q),
      .dsel_q     (dsel_q),
      .src_ins_q  (src_ins_q),
      .dst_ins_q  (dst_ins_q),
      .src_q      (src_q),
      .dst_q      (dst_q),
      .pend_q     (pend_q),
      .pend_sel_q (pend_sel_q)
   );

   cam_read_mux #(.REG_W(REG_W), .DEV_ID(DEV_ID)) u_rmux (
      .cyc_type   (cyc_type),
      .pend_q     (pend_q),
      .pend_sel_q (pend_sel_q),
      .adr_q      (adr_q),
      .ctl_q      (ctl_q),
      .page_q     (page_q),
      .seg_q      (seg_q),
      .dsel_q     (dsel_q),
      .src_ins_q  (src_ins_q),
      .dst_ins_q  (dst_ins_q),
      .nfa_in     (nfa_in),
      .status_in  (status_in),
      .rd_data_in (rd_data_in),
      .rd_word    (rd_word)
   );

   assign is_rd   = bus_wr_n;
   assign is_dat  = bus_cd;
   assign dq_oe   = cyc_act && is_rd && rd_ok;
   assign dq_out  = dq_oe ? rd_word : '0;
   assign act_res = is_rd ? src_q : dst_q;
   assign req_vld = cyc_act && is_dat && (is_rd ? rd_ok : wr_ok);
   assign req_wr  = req_vld && !is_rd;
   assign req_res = req_vld ? act_res : RES_CMP;

   always_comb begin
      req_addr = '0;
      if (req_vld) begin
         case (act_res)
            RES_ARR_ADR: req_addr = adr_q;
            RES_ARR_NFA: req_addr = nfa_in;
            default:     req_addr = '0;
         endcase
      end
   end

   assign req_wdata = req_wr ? dq_in : '0;
endmodule

// File: rtl/cam_host_chk.sv
module cam_host_chk #(
   parameter int REG_W  = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en_n,
   input logic              bus_cd,
   input logic              bus_wr_n,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_out,
   input logic              req_vld,
   input logic              req_wr,
   input logic [REG_W-1:0]  page_q,
   input logic [REG_W-1:0]  dsel_q,
   input logic              pend_q,
   input logic [3:0]        pend_sel_q,
   input logic [2:0]        src_q,
   input logic [2:0]        dst_q
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en_n |-> (!dq_oe && !req_vld));

   a_r7_req_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |-> (!bus_en_n && bus_cd && (req_wr == !bus_wr_n)));

   a_r8_no_read_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (dsel_q != page_q) |-> !dq_oe);

   a_r5_page_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && (pend_sel_q == 4'd2) && dq_oe && !bus_cd) |-> (dq_out[DATA_W-1:REG_W] == '0));

   a_r10_arm_after_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> ($past(!bus_en_n) && $past(!bus_cd) && $past(!bus_wr_n)));

   a_r6_reset_comparand: assert property (@(posedge clk)
      $rose(rst_n) |-> ((src_q == 3'd0) && (dst_q == 3'd0)));
endmodule

bind cam_host_if cam_host_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_en_n   (bus_en_n),
   .bus_cd     (bus_cd),
   .bus_wr_n   (bus_wr_n),
   .dq_oe      (dq_oe),
   .dq_out     (dq_out),
   .req_vld    (req_vld),
   .req_wr     (req_wr),
   .page_q     (page_q),
   .dsel_q     (dsel_q),
   .pend_q     (pend_q),
   .pend_sel_q (pend_sel_q),
   .src_q      (src_q),
   .dst_q      (dst_q)
);

// File: tb/test_cam_host_if.sv
module test_cam_host_if;
   localparam logic [15:0] DEV  = 16'h0C3A;
   localparam logic [31:0] STAT = 32'hA5C3_1E0F;
   localparam logic [15:0] NFA  = 16'h0123;
   localparam logic [31:0] RDAT = 32'hDEAD_BEEF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en_n = 1'b1, bus_cd = 1'b0, bus_wr_n = 1'b1;
   logic [31:0] dq_in = '0;
   logic [31:0] dq_out;
   logic        dq_oe;
   logic        req_vld, req_wr;
   logic [2:0]  req_res;
   logic [15:0] req_addr;
   logic [31:0] req_wdata;

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [15:0] m_reg [5];
   int          m_src, m_dst;
   logic [15:0] m_src_ins, m_dst_ins;
   bit          m_pend;
   int          m_psel;

   always #5 clk = ~clk;

   cam_host_if #(.DEV_ID(DEV)) i_cam_host_if (
      .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .bus_cd(bus_cd),
      .bus_wr_n(bus_wr_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .nfa_in(NFA), .status_in(STAT), .rd_data_in(RDAT),
      .req_vld(req_vld), .req_wr(req_wr), .req_res(req_res),
      .req_addr(req_addr), .req_wdata(req_wdata)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 5; i++) m_reg[i] = '0;
      m_src = 0; m_dst = 0; m_src_ins = '0; m_dst_ins = '0;
      m_pend = 0; m_psel = 0;
   endtask

   // one bus clock: drive, compare against model, advance model
   task automatic cyc(bit en_n, bit cd, bit wr_n, logic [31:0] d, string tag);
      bit          sel, wok, rd, oe, vld;
      int          res, op, code;
      logic [31:0] exp_dq;
      logic [15:0] exp_addr;
      @(negedge clk);
      bus_en_n = en_n; bus_cd = cd; bus_wr_n = wr_n; dq_in = d;
      #4;
      sel = (m_reg[4] == m_reg[2]);
      wok = sel || (m_reg[4] == 16'hFFFF);
      rd  = !en_n && wr_n;
      oe  = rd && sel;
      exp_dq = '0;
      if (oe && cd) exp_dq = RDAT;
      else if (oe) begin
         exp_dq = STAT;
         if (m_pend) begin
            if (m_psel <= 4 && m_psel != 2) exp_dq = {STAT[31:16], m_reg[m_psel]};
            else if (m_psel == 2) exp_dq = {16'h0000, m_reg[2]};
            else if (m_psel == 5) exp_dq = {STAT[31:16], NFA};
            else if (m_psel == 6) exp_dq = {DEV, m_src_ins};
            else if (m_psel == 7) exp_dq = {STAT[31:16], m_dst_ins};
         end
      end
      vld = !en_n && cd && (wr_n ? sel : wok);
      res = wr_n ? m_src : m_dst;
      exp_addr = '0;
      if (vld && res == 3) exp_addr = m_reg[0];
      if (vld && res == 4) exp_addr = NFA;
      chk(tag, "dq_oe", 32'(dq_oe), 32'(oe));
      chk(tag, "dq_out", dq_out, exp_dq);
      chk(tag, "req_vld", 32'(req_vld), 32'(vld));
      if (vld) begin
         chk(tag, "req_wr", 32'(req_wr), 32'(!wr_n));
         chk(tag, "req_res", 32'(req_res), 32'(res));
         chk(tag, "req_addr", 32'(req_addr), 32'(exp_addr));
         if (!wr_n) chk(tag, "req_wdata", req_wdata, d);
      end
      // advance model
      op   = int'(d[31:28]);
      code = int'(d[19:16]);
      m_pend = 0;
      if (!en_n && !cd && !wr_n) begin
         if (op == 1 && d[20] && code == 4) m_reg[4] = d[15:0];
         else if (wok) begin
            if (op == 1 && d[20] && code < 4) m_reg[code] = d[15:0];
            if (op == 1 && !d[20]) begin m_pend = 1; m_psel = code; end
            if (op == 2 && (code & 7) <= 5 && (code & 7) != 4) begin
               m_src = code & 7; m_src_ins = d[31:16];
            end
            if (op == 3 && (code & 7) <= 5) begin
               m_dst = code & 7; m_dst_ins = d[31:16];
            end
         end
      end
   endtask

   function automatic logic [31:0] ld(int code, logic [15:0] v);
      return {4'h1, 7'd0, 1'b1, 4'(code), v};
   endfunction
   function automatic logic [31:0] arm(int code);
      return {4'h1, 7'd0, 1'b0, 4'(code), 16'h0000};
   endfunction
   function automatic logic [31:0] sel_src(int r);
      return {4'h2, 9'd0, 3'(r), 16'h0000};
   endfunction
   function automatic logic [31:0] sel_dst(int r);
      return {4'h3, 9'd0, 3'(r), 16'h0000};
   endfunction

   initial begin
      #(150000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, idle clocks
      cyc(1, 0, 1, '0, "R1");
      cyc(1, 1, 0, 32'h1234_5678, "R1");
      // R2 default status
      cyc(0, 0, 1, '0, "R2");
      // R6 reset selections, R7 requests
      cyc(0, 1, 0, 32'h0BAD_F00D, "R6");
      cyc(0, 1, 1, '0, "R6");
      // R3 loads, R4 armed reads
      cyc(0, 0, 0, ld(0, 16'h0040), "R3");
      cyc(0, 0, 0, ld(1, 16'h1111), "R3");
      cyc(0, 0, 0, ld(3, 16'h2222), "R3");
      cyc(0, 0, 0, ld(9, 16'h7777), "R3");
      cyc(0, 0, 0, arm(0), "R4"); cyc(0, 0, 1, '0, "R4");
      cyc(0, 0, 0, arm(1), "R4"); cyc(0, 0, 1, '0, "R4");
      cyc(0, 0, 0, arm(3), "R4"); cyc(0, 0, 1, '0, "R4");
      cyc(0, 0, 0, arm(5), "R4"); cyc(0, 0, 1, '0, "R4");
      cyc(0, 0, 0, arm(9), "R4"); cyc(0, 0, 1, '0, "R4");
      // R5 page read with zero upper half
      cyc(0, 0, 0, ld(2, 16'h0007), "R8");
      cyc(0, 0, 1, '0, "R8");
      cyc(0, 0, 0, ld(4, 16'h0007), "R8");
      cyc(0, 0, 0, arm(2), "R5"); cyc(0, 0, 1, '0, "R5");
      cyc(0, 0, 0, arm(4), "R4"); cyc(0, 0, 1, '0, "R4");
      // R7 routing of each resource
      cyc(0, 0, 0, sel_dst(3), "R7"); cyc(0, 1, 0, 32'h0000_0A0A, "R7");
      cyc(0, 0, 0, sel_dst(4), "R7"); cyc(0, 1, 0, 32'h0000_0B0B, "R7");
      cyc(0, 0, 0, sel_dst(5), "R7"); cyc(0, 1, 0, 32'h0000_0C0C, "R7");
      cyc(0, 0, 0, sel_dst(2), "R7"); cyc(0, 1, 0, 32'h0000_0D0D, "R7");
      cyc(0, 0, 0, sel_src(1), "R7"); cyc(0, 1, 1, '0, "R7");
      cyc(0, 0, 0, sel_src(3), "R7"); cyc(0, 1, 1, '0, "R7");
      cyc(0, 0, 0, sel_src(5), "R7"); cyc(0, 1, 1, '0, "R7");
      // R11 invalid selections ignored
      cyc(0, 0, 0, sel_src(4), "R11"); cyc(0, 1, 1, '0, "R11");
      cyc(0, 0, 0, sel_src(7), "R11"); cyc(0, 1, 1, '0, "R11");
      cyc(0, 0, 0, sel_dst(6), "R11"); cyc(0, 1, 0, 32'h0000_0E0E, "R11");
      // R9 selection readback
      cyc(0, 0, 0, arm(6), "R9"); cyc(0, 0, 1, '0, "R9");
      cyc(0, 0, 0, arm(7), "R9"); cyc(0, 0, 1, '0, "R9");
      // R6 restore comparand
      cyc(0, 0, 0, sel_src(0), "R6"); cyc(0, 1, 1, '0, "R6");
      cyc(0, 0, 0, sel_dst(0), "R6"); cyc(0, 1, 0, 32'h0000_0F0F, "R6");
      // R10 cancellation by data cycle and by idle clock
      cyc(0, 0, 0, arm(0), "R10"); cyc(0, 1, 0, 32'h1, "R10"); cyc(0, 0, 1, '0, "R10");
      cyc(0, 0, 0, arm(1), "R10"); cyc(1, 0, 1, '0, "R10"); cyc(0, 0, 1, '0, "R10");
      cyc(0, 0, 0, arm(3), "R10"); cyc(0, 0, 0, ld(9, 16'h0), "R10"); cyc(0, 0, 1, '0, "R10");
      // R8 deselected: nothing accepted but device-select load
      cyc(0, 0, 0, ld(4, 16'h0009), "R8");
      cyc(0, 0, 1, '0, "R8");
      cyc(0, 1, 1, '0, "R8");
      cyc(0, 1, 0, 32'h0000_5555, "R8");
      cyc(0, 0, 0, ld(0, 16'h0055), "R8");
      cyc(0, 0, 0, ld(4, 16'h0007), "R8");
      cyc(0, 0, 0, arm(0), "R8"); cyc(0, 0, 1, '0, "R8");
      // R8 write-only broadcast code
      cyc(0, 0, 0, ld(4, 16'hFFFF), "R8");
      cyc(0, 1, 0, 32'h0000_6666, "R8");
      cyc(0, 1, 1, '0, "R8");
      cyc(0, 0, 1, '0, "R8");
      cyc(0, 0, 0, ld(0, 16'h0099), "R8");
      cyc(0, 0, 0, ld(4, 16'h0007), "R8");
      cyc(0, 0, 0, arm(0), "R8"); cyc(0, 0, 1, '0, "R8");
      cyc(1, 0, 1, '0, "R1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule